// File: doc/BRIEF.md
# Reorder Window with Dataflow Dispatch

This block is a circular instruction window that sits between rename and the functional units of an out-of-order core. Decode hands it one renamed instruction per cycle, in program order. Each source operand arrives either as a value or as the tag of the in-flight instruction that will produce it. The window keeps each instruction in a slot until both operands are present. It then sends the oldest such instruction to the functional units, at most one per cycle.

Finished instructions report on a shared result bus as a tag, a value and an optional fault. Every waiting source that names that tag takes the value. The producing slot stores the value as its result. Results leave the window strictly in program order on a register write port. When the oldest instruction carries a fault, the window discards every instruction it holds and reports the fault cause for one cycle.

A slot's tag is its index. The depth must be a power of two, and the data width must be at least the tag width.

Top module: `reorder_window`

## Requirements
- R1: After reset the window is empty: alloc_ready is 1, alloc_tag is 0, and disp_valid, cmt_valid and flush are 0.
- R2: An instruction is accepted when alloc_valid and alloc_ready are both 1 at a clock edge. It takes the slot given by alloc_tag, and successive accepted instructions get consecutive tags modulo DEPTH. alloc_ready is 0 while all DEPTH slots are occupied, and a request made then changes nothing.
- R3: A slot is offered on the dispatch port only when both of its operands are present. It is offered exactly once, in the cycle after the edge that made it eligible, together with its opcode and both operand values.
- R4: When several slots are eligible, the oldest one in program order is dispatched first, including across the wrap of the circular buffer. At most one slot is dispatched per cycle.
- R5: A source that is not present holds the producer tag in bits [TAG_W-1:0] of its value. A result broadcast that names that tag makes the source present with the broadcast value.
- R6: A result broadcast in the same cycle as an allocation whose waiting source names the broadcast tag is forwarded into the new slot. That slot is then eligible in the next cycle.
- R7: A result broadcast is accepted only for a slot that has been dispatched and has not yet completed. Any other broadcast changes neither completion, result data nor operand readiness.
- R8: cmt_valid presents the oldest slot's destination register and result once that slot has completed without a fault. Retirement happens one slot per cycle, in program order, whatever order the results arrive in.
- R9: When the oldest slot completes with a fault, flush is 1 for one cycle with that slot's cause on flush_cause, and nothing commits. The window is then empty, and the next allocation reuses the faulting slot's tag.
- R10: alloc_ready is 0 in any cycle in which flush is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_ready | output | 1 | Window can accept an instruction this cycle |
| alloc_tag | output | TAG_W | Slot the next accepted instruction takes |
| alloc_op | input | OP_W | Opcode of the offered instruction |
| alloc_a_rdy | input | 1 | First source holds a value |
| alloc_a | input | DATA_W | First source value, or producer tag in the low bits |
| alloc_b_rdy | input | 1 | Second source holds a value |
| alloc_b | input | DATA_W | Second source value, or producer tag in the low bits |
| alloc_dst | input | REG_W | Architectural destination register |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | TAG_W | Slot that produced the result |
| res_data | input | DATA_W | Result value |
| res_exc | input | 1 | Producing instruction faulted |
| res_cause | input | CAUSE_W | Fault cause |
| disp_valid | output | 1 | An instruction is dispatched this cycle |
| disp_tag | output | TAG_W | Slot of the dispatched instruction |
| disp_op | output | OP_W | Opcode of the dispatched instruction |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| cmt_valid | output | 1 | Register write of the oldest result |
| cmt_dst | output | REG_W | Destination register of the write |
| cmt_data | output | DATA_W | Value written |
| flush | output | 1 | Oldest instruction faulted; window is cleared |
| flush_cause | output | CAUSE_W | Cause of the fault |

## Verification
A lost wakeup or a wrongly set exec bit shows up on the dispatch port in the very next cycle: a slot appears twice, carries a stale operand value, or never appears. A corrupted completion bit or result field only becomes visible when that slot reaches the commit pointer, so checks compare the whole retirement sequence against values computed from the allocated operands. Pointer faults show up on alloc_tag one cycle after an allocation, or after a flush, and an occupancy error shows up when alloc_ready disagrees with the bench's own count of slots in use.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Condition of the slot at the commit pointer
  typedef enum logic [1:0] {
    HS_EMPTY  = 2'd0,
    HS_WAIT   = 2'd1,
    HS_RETIRE = 2'd2,
    HS_FAULT  = 2'd3
  } head_state_e;

endpackage

// File: rtl/rob_pick.sv
// Oldest-first selection among ready slots, scanning from the commit pointer.
module rob_pick #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input  logic [DEPTH-1:0] ready,
  input  logic [TAG_W-1:0] head,
  output logic             found,
  output logic [TAG_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = head;
    for (int k = 0; k < DEPTH; k++) begin
      if (!found && ready[head + TAG_W'(k)]) begin
        found = 1'b1;
        idx   = head + TAG_W'(k);
      end
    end
  end

endmodule

// File: rtl/rob_ptr.sv
// Circular slot pointer with advance and load.
module rob_ptr #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [TAG_W-1:0] load_val,
  output logic [TAG_W-1:0] q
);

  logic [TAG_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (load)     nxt = load_val;
    else if (adv) nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/reorder_window.sv
module reorder_window
  import rob_pkg::*;
#(
  parameter  int DEPTH   = 8,
  parameter  int DATA_W  = 16,
  parameter  int OP_W    = 4,
  parameter  int REG_W   = 5,
  parameter  int CAUSE_W = 4,
  localparam int TAG_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  output logic [TAG_W-1:0]   alloc_tag,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic               alloc_a_rdy,
  input  logic [DATA_W-1:0]  alloc_a,
  input  logic               alloc_b_rdy,
  input  logic [DATA_W-1:0]  alloc_b,
  input  logic [REG_W-1:0]   alloc_dst,
  input  logic               res_valid,
  input  logic [TAG_W-1:0]   res_tag,
  input  logic [DATA_W-1:0]  res_data,
  input  logic               res_exc,
  input  logic [CAUSE_W-1:0] res_cause,
  output logic               disp_valid,
  output logic [TAG_W-1:0]   disp_tag,
  output logic [OP_W-1:0]    disp_op,
  output logic [DATA_W-1:0]  disp_a,
  output logic [DATA_W-1:0]  disp_b,
  output logic               cmt_valid,
  output logic [REG_W-1:0]   cmt_dst,
  output logic [DATA_W-1:0]  cmt_data,
  output logic               flush,
  output logic [CAUSE_W-1:0] flush_cause
);

  // Per-slot control bits (reset) and payload (not reset)
  logic [DEPTH-1:0]   use_q, use_d, exec_q, exec_d, done_q, done_d;
  logic [DEPTH-1:0]   pa_q, pa_d, pb_q, pb_d, exc_q, exc_d;
  logic [DATA_W-1:0]  va_q [DEPTH];
  logic [DATA_W-1:0]  va_d [DEPTH];
  logic [DATA_W-1:0]  vb_q [DEPTH];
  logic [DATA_W-1:0]  vb_d [DEPTH];
  logic [DATA_W-1:0]  rd_q [DEPTH];
  logic [DATA_W-1:0]  rd_d [DEPTH];
  logic [OP_W-1:0]    op_q [DEPTH];
  logic [OP_W-1:0]    op_d [DEPTH];
  logic [REG_W-1:0]   dst_q [DEPTH];
  logic [REG_W-1:0]   dst_d [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];
  logic [CAUSE_W-1:0] cause_d [DEPTH];

  logic [TAG_W-1:0] head_q, tail_q, pick_idx;
  logic             pick_found, res_hit, alloc_fire, retire, fault;
  logic             fwd_a, fwd_b;
  logic [DEPTH-1:0] ready_vec;
  head_state_e      hs;

  // Head slot condition
  always_comb begin
    if (!use_q[head_q])      hs = HS_EMPTY;
    else if (!done_q[head_q]) hs = HS_WAIT;
    else if (exc_q[head_q])   hs = HS_FAULT;
    else                      hs = HS_RETIRE;
  end

  assign retire      = (hs == HS_RETIRE);
  assign fault       = (hs == HS_FAULT);
  assign alloc_ready = !use_q[tail_q] && !fault;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;

  // A result counts only for a dispatched, not yet completed slot
  assign res_hit = res_valid && use_q[res_tag] && exec_q[res_tag] && !done_q[res_tag];
  assign fwd_a   = res_hit && !alloc_a_rdy && (alloc_a[TAG_W-1:0] == res_tag);
  assign fwd_b   = res_hit && !alloc_b_rdy && (alloc_b[TAG_W-1:0] == res_tag);

  assign ready_vec = use_q & ~exec_q & pa_q & pb_q;

  rob_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
    .ready (ready_vec),
    .head  (head_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  rob_ptr #(.TAG_W(TAG_W)) u_head (
    .clk(clk), .rst_n(rst_n), .adv(retire), .load(1'b0),
    .load_val(head_q), .q(head_q)
  );

  rob_ptr #(.TAG_W(TAG_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .adv(alloc_fire), .load(fault),
    .load_val(head_q), .q(tail_q)
  );

  // Next-state
  always_comb begin
    use_d = use_q;  exec_d = exec_q;  done_d = done_q;
    pa_d  = pa_q;   pb_d   = pb_q;    exc_d  = exc_q;
    va_d  = va_q;   vb_d   = vb_q;    rd_d   = rd_q;
    op_d  = op_q;   dst_d  = dst_q;   cause_d = cause_q;

    // Wakeup of waiting sources from the result bus
    for (int i = 0; i < DEPTH; i++) begin
      if (res_hit && use_q[i] && !pa_q[i] && (va_q[i][TAG_W-1:0] == res_tag)) begin
        pa_d[i] = 1'b1;
        va_d[i] = res_data;
      end
      if (res_hit && use_q[i] && !pb_q[i] && (vb_q[i][TAG_W-1:0] == res_tag)) begin
        pb_d[i] = 1'b1;
        vb_d[i] = res_data;
      end
    end

    if (pick_found) exec_d[pick_idx] = 1'b1;

    if (res_hit) begin
      done_d[res_tag]  = 1'b1;
      rd_d[res_tag]    = res_data;
      exc_d[res_tag]   = res_exc;
      cause_d[res_tag] = res_cause;
    end

    if (retire) use_d[head_q] = 1'b0;

    if (alloc_fire) begin
      use_d[tail_q]  = 1'b1;
      exec_d[tail_q] = 1'b0;
      done_d[tail_q] = 1'b0;
      op_d[tail_q]   = alloc_op;
      dst_d[tail_q]  = alloc_dst;
      pa_d[tail_q]   = alloc_a_rdy || fwd_a;
      va_d[tail_q]   = fwd_a ? res_data : alloc_a;
      pb_d[tail_q]   = alloc_b_rdy || fwd_b;
      vb_d[tail_q]   = fwd_b ? res_data : alloc_b;
    end

    if (fault) use_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q  <= '0;
      exec_q <= '0;
      done_q <= '0;
      pa_q   <= '0;
      pb_q   <= '0;
      exc_q  <= '0;
    end else begin
      use_q  <= use_d;
      exec_q <= exec_d;
      done_q <= done_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
      exc_q  <= exc_d;
    end
  end

  always_ff @(posedge clk) begin
    va_q    <= va_d;
    vb_q    <= vb_d;
    rd_q    <= rd_d;
    op_q    <= op_d;
    dst_q   <= dst_d;
    cause_q <= cause_d;
  end

  assign disp_valid  = pick_found;
  assign disp_tag    = pick_idx;
  assign disp_op     = op_q[pick_idx];
  assign disp_a      = va_q[pick_idx];
  assign disp_b      = vb_q[pick_idx];
  assign cmt_valid   = retire;
  assign cmt_dst     = dst_q[head_q];
  assign cmt_data    = rd_q[head_q];
  assign flush       = fault;
  assign flush_cause = cause_q[head_q];

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             disp_valid,
  input logic [TAG_W-1:0] disp_tag,
  input logic             cmt_valid,
  input logic             flush,
  input logic [TAG_W-1:0] head
);

  localparam logic [TAG_W:0] FULL = (TAG_W+1)'(DEPTH);

  logic             fire;
  logic [TAG_W:0]   occ;
  logic [DEPTH-1:0] seen;

  assign fire = alloc_valid && alloc_ready;

  // Independent occupancy count and dispatched-slot record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= '0;
      seen <= '0;
    end else if (flush) begin
      occ  <= '0;
      seen <= '0;
    end else begin
      occ <= occ + (TAG_W+1)'(fire) - (TAG_W+1)'(cmt_valid);
      if (disp_valid) seen[disp_tag] <= 1'b1;
      if (cmt_valid)  seen[head]     <= 1'b0;
    end
  end

  p_tag_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> alloc_tag == TAG_W'($past(alloc_tag) + 1'b1));

  p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL) |-> !alloc_ready);

  p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> (occ < FULL));

  p_disp_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !seen[disp_tag]);

  p_cmt_dispatched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> seen[head]);

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_tag == head) && alloc_ready && !disp_valid && !cmt_valid && !flush);

  p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready);

endmodule

bind reorder_window rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready),
  .alloc_tag  (alloc_tag),
  .disp_valid (disp_valid),
  .disp_tag   (disp_tag),
  .cmt_valid  (cmt_valid),
  .flush      (flush),
  .head       (head_q)
);

// File: tb/sim_reorder_window.sv
`timescale 1ns/1ps
module sim_reorder_window;

  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int OW    = 4;
  localparam int RW    = 5;
  localparam int CW    = 4;
  localparam int TW    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_valid, alloc_ready, alloc_a_rdy, alloc_b_rdy;
  logic [TW-1:0] alloc_tag;
  logic [OW-1:0] alloc_op;
  logic [DW-1:0] alloc_a, alloc_b;
  logic [RW-1:0] alloc_dst;
  logic          res_valid, res_exc;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;
  logic [CW-1:0] res_cause;
  logic          disp_valid, cmt_valid, flush;
  logic [TW-1:0] disp_tag;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b, cmt_data;
  logic [RW-1:0] cmt_dst;
  logic [CW-1:0] flush_cause;

  always #4 clk = ~clk;

  reorder_window #(.DEPTH(DEPTH), .DATA_W(DW), .OP_W(OW), .REG_W(RW), .CAUSE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .alloc_op(alloc_op), .alloc_a_rdy(alloc_a_rdy), .alloc_a(alloc_a),
    .alloc_b_rdy(alloc_b_rdy), .alloc_b(alloc_b), .alloc_dst(alloc_dst),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .res_exc(res_exc), .res_cause(res_cause),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b),
    .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_data(cmt_data),
    .flush(flush), .flush_cause(flush_cause)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  // Mid-cycle logs of what the ports present
  int            dn = 0;
  logic [TW-1:0] d_tag [512];
  logic [OW-1:0] d_op  [512];
  logic [DW-1:0] d_a   [512];
  logic [DW-1:0] d_b   [512];
  int            cn = 0;
  logic [RW-1:0] c_dst [512];
  logic [DW-1:0] c_data[512];
  int            fn = 0;
  logic [CW-1:0] f_cause[16];
  logic          f_ar  [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (disp_valid && dn < 512) begin
        d_tag[dn] = disp_tag; d_op[dn] = disp_op; d_a[dn] = disp_a; d_b[dn] = disp_b;
        dn++;
      end
      if (cmt_valid && cn < 512) begin
        c_dst[cn] = cmt_dst; c_data[cn] = cmt_data;
        cn++;
      end
      if (flush && fn < 16) begin
        f_cause[fn] = flush_cause; f_ar[fn] = alloc_ready;
        fn++;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fu_result(input logic [OW-1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a + b) ^ {12'h0, op};
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_alloc(input logic [OW-1:0] op, input logic ar, input logic [DW-1:0] a,
                          input logic br, input logic [DW-1:0] b, input logic [RW-1:0] dst,
                          output logic [TW-1:0] tag);
    alloc_op = op; alloc_a_rdy = ar; alloc_a = a; alloc_b_rdy = br; alloc_b = b; alloc_dst = dst;
    tag = alloc_tag;
    alloc_valid = 1'b1;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic do_res(input logic [TW-1:0] tag, input logic [DW-1:0] data,
                        input logic exc, input logic [CW-1:0] cause);
    res_tag = tag; res_data = data; res_exc = exc; res_cause = cause;
    res_valid = 1'b1;
    tick();
    res_valid = 1'b0; res_exc = 1'b0;
  endtask

  initial begin
    logic [TW-1:0] t;
    logic [DW-1:0] va, vb, vc, vd, ve, vv, r1, r2, r3, r4;
    int bd, bc;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    alloc_valid = 0; alloc_op = 0; alloc_a_rdy = 0; alloc_a = 0; alloc_b_rdy = 0; alloc_b = 0;
    alloc_dst = 0; res_valid = 0; res_tag = 0; res_data = 0; res_exc = 0; res_cause = 0;
    tick(3);
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
    chk(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);
    chk(!disp_valid && !cmt_valid && !flush, "R1 idle outputs",
        {disp_valid, cmt_valid, flush}, 0);

    // Scenario: wakeup, ignored broadcast, forwarding, ordered retirement
    bd = dn; bc = cn;
    va = 16'h1234; vb = 16'h0F0F; vc = 16'h0042; vd = 16'h7001; ve = 16'h0BEE;
    vv = 16'h5A5A; r1 = 16'h1111; r2 = 16'h2222; r3 = 16'h3333; r4 = 16'h4444;
    do_alloc(4'h1, 1, va, 1, vb, 5'd1, t);
    chk(t == 0, "R2 first tag", t, 0);
    do_alloc(4'h2, 0, 16'h0000, 1, vc, 5'd2, t);   // waits on tag 0
    chk(t == 1, "R2 tag seq", t, 1);
    do_alloc(4'h3, 1, vd, 0, 16'h0000, 5'd3, t);   // waits on tag 0
    do_alloc(4'h4, 0, 16'h0000, 0, 16'h0000, 5'd4, t);
    chk(t == 3, "R2 tag seq 3", t, 3);
    do_res(3'd3, 16'hDEAD, 1'b0, 4'h0);           // slot 3 not dispatched: ignored
    chk(dn - bd == 1, "R7 junk broadcast woke nothing", dn - bd, 1);
    // broadcast tag 0 while allocating a slot that waits on it
    alloc_op = 4'h5; alloc_a_rdy = 0; alloc_a = 16'h0000; alloc_b_rdy = 1; alloc_b = ve; alloc_dst = 5'd5;
    res_tag = 3'd0; res_data = vv; res_exc = 0; res_cause = 0;
    alloc_valid = 1; res_valid = 1;
    tick();
    alloc_valid = 0; res_valid = 0;
    tick(6);
    chk(dn - bd == 5, "R3 dispatch count", dn - bd, 5);
    chk(d_tag[bd] == 0 && d_a[bd] == va && d_b[bd] == vb && d_op[bd] == 4'h1,
        "R3 ready slot dispatched", d_a[bd], va);
    chk(d_tag[bd+1] == 1 && d_a[bd+1] == vv && d_b[bd+1] == vc, "R4 oldest first, R5 a-wake",
        {d_tag[bd+1], d_a[bd+1]}, {3'd1, vv});
    chk(d_tag[bd+2] == 2 && d_a[bd+2] == vd && d_b[bd+2] == vv, "R5 b-wake",
        {d_tag[bd+2], d_b[bd+2]}, {3'd2, vv});
    chk(d_tag[bd+3] == 3 && d_a[bd+3] == vv && d_b[bd+3] == vv, "R5 both wake",
        {d_tag[bd+3], d_a[bd+3]}, {3'd3, vv});
    chk(d_tag[bd+4] == 4 && d_a[bd+4] == vv && d_b[bd+4] == ve, "R6 forward on alloc",
        {d_tag[bd+4], d_a[bd+4]}, {3'd4, vv});
    do_res(3'd3, r3, 0, 0);
    do_res(3'd2, r2, 0, 0);
    chk(cn - bc == 1, "R8 no out-of-order commit", cn - bc, 1);
    do_res(3'd1, r1, 0, 0);
    do_res(3'd4, r4, 0, 0);
    tick(6);
    chk(cn - bc == 5, "R8 commit count", cn - bc, 5);
    chk(c_dst[bc] == 1 && c_data[bc] == vv, "R8 commit 0", c_data[bc], vv);
    chk(c_dst[bc+1] == 2 && c_data[bc+1] == r1, "R8 commit 1", c_data[bc+1], r1);
    chk(c_dst[bc+2] == 3 && c_data[bc+2] == r2, "R8 commit 2", c_data[bc+2], r2);
    chk(c_dst[bc+3] == 4 && c_data[bc+3] == r3, "R7 junk not kept, R8 commit 3", c_data[bc+3], r3);
    chk(c_dst[bc+4] == 5 && c_data[bc+4] == r4, "R8 commit 4", c_data[bc+4], r4);

    // Scenario: fault at the head
    bc = cn;
    do_alloc(4'h6, 1, 16'h0001, 1, 16'h0002, 5'd6, t);
    chk(t == 5, "R2 tag after wrap region", t, 5);
    do_alloc(4'h7, 1, 16'h0003, 1, 16'h0004, 5'd7, t);
    tick(2);
    do_res(3'd6, 16'h6666, 0, 0);
    chk(cn == bc && !flush, "R8 younger done waits", cn - bc, 0);
    do_res(3'd5, 16'h5555, 1, 4'hA);
    chk(flush == 1'b1 && flush_cause == 4'hA, "R9 flush cause", {flush, flush_cause}, {1'b1, 4'hA});
    chk(alloc_ready == 1'b0, "R10 no alloc during flush", alloc_ready, 0);
    tick();
    chk(!flush && alloc_ready && alloc_tag == 5, "R9 window empty after flush",
        {flush, alloc_ready, alloc_tag}, {1'b0, 1'b1, 3'd5});
    chk(cn == bc && fn == 1 && f_ar[0] == 1'b0, "R9 one flush cycle, no commit", {cn - bc, fn}, {32'd0, 32'd1});
    do_alloc(4'h8, 1, 16'h0010, 1, 16'h0020, 5'd8, t);
    chk(t == 5, "R9 faulting tag reused", t, 5);
    tick();
    do_res(3'd5, 16'h0ABC, 0, 0);
    tick(2);
    chk(cn - bc == 1 && c_data[bc] == 16'h0ABC, "R8 commit after flush", c_data[bc], 16'h0ABC);

    // Scenario: full window, wrap-around ordering
    begin
      logic [DW-1:0] bz[8];
      logic [DW-1:0] rz[8];
      logic [TW-1:0] tz[8];
      int perm[8];
      bd = dn; bc = cn;
      do_alloc(4'h9, 1, 16'h0100, 1, 16'h0200, 5'd20, tz[0]);
      chk(tz[0] == 6, "R2 tag 6", tz[0], 6);
      for (int k = 1; k < 8; k++) begin
        bz[k] = DW'($urandom);
        rz[k] = DW'($urandom);
        do_alloc(4'h2, 0, {13'h0, 3'd6}, 1, bz[k], RW'(20 + k), tz[k]);
      end
      chk(alloc_ready == 1'b0, "R2 full", alloc_ready, 0);
      do_alloc(4'hF, 1, 16'hFFFF, 1, 16'hFFFF, 5'd31, t);
      chk(alloc_tag == 6 && alloc_ready == 1'b0, "R2 request while full ignored", alloc_tag, 6);
      do_res(3'd6, vv, 0, 0);
      tick(9);
      chk(dn - bd == 8, "R3 full dispatch count", dn - bd, 8);
      for (int k = 1; k < 8; k++)
        chk(d_tag[bd+k] == TW'(6 + k) && d_a[bd+k] == vv && d_b[bd+k] == bz[k],
            "R4 oldest across wrap", d_tag[bd+k], TW'(6 + k));
      for (int k = 0; k < 7; k++) perm[k] = k + 1;
      for (int k = 6; k > 0; k--) begin
        int j; int s;
        j = int'($urandom % 32'(k + 1));
        s = perm[k]; perm[k] = perm[j]; perm[j] = s;
      end
      for (int k = 0; k < 7; k++) do_res(tz[perm[k]], rz[perm[k]], 0, 0);
      tick(10);
      chk(cn - bc == 8, "R8 full commit count", cn - bc, 8);
      chk(c_dst[bc] == 5'd20 && c_data[bc] == vv, "R8 full commit head", c_data[bc], vv);
      for (int k = 1; k < 8; k++)
        chk(c_dst[bc+k] == RW'(20 + k) && c_data[bc+k] == rz[k], "R8 full in order",
            c_data[bc+k], rz[k]);
      chk(alloc_ready == 1'b1, "R2 room after drain", alloc_ready, 1);
    end

    // Constrained random rounds of independent instructions
    for (int r = 0; r < 20; r++) begin
      int n;
      logic [TW-1:0] tg[8];
      logic [DW-1:0] ea[8], eb[8], ex[8];
      logic [OW-1:0] eo[8];
      logic [RW-1:0] ed[8];
      int perm[8];
      n = 1 + int'($urandom % 8);
      bd = dn; bc = cn;
      for (int k = 0; k < n; k++) begin
        ea[k] = DW'($urandom); eb[k] = DW'($urandom);
        eo[k] = OW'($urandom); ed[k] = RW'($urandom);
        ex[k] = fu_result(eo[k], ea[k], eb[k]);
        do_alloc(eo[k], 1, ea[k], 1, eb[k], ed[k], tg[k]);
        chk(tg[k] == TW'(tg[0] + TW'(k)), "R2 random tag seq", tg[k], TW'(tg[0] + TW'(k)));
      end
      tick(2);
      chk(dn - bd == n, "R3 random dispatch count", dn - bd, n);
      for (int k = 0; k < n; k++)
        chk(d_tag[bd+k] == tg[k] && d_a[bd+k] == ea[k] && d_b[bd+k] == eb[k] && d_op[bd+k] == eo[k],
            "R3 random dispatch operands", {d_tag[bd+k], d_a[bd+k]}, {tg[k], ea[k]});
      for (int k = 0; k < n; k++) perm[k] = k;
      for (int k = n - 1; k > 0; k--) begin
        int j; int s;
        j = int'($urandom % 32'(k + 1));
        s = perm[k]; perm[k] = perm[j]; perm[j] = s;
      end
      for (int k = 0; k < n; k++) do_res(tg[perm[k]], ex[perm[k]], 0, 0);
      tick(n + 2);
      chk(cn - bc == n, "R8 random commit count", cn - bc, n);
      for (int k = 0; k < n; k++)
        chk(c_dst[bc+k] == ed[k] && c_data[bc+k] == ex[k], "R8 random commit order",
            {c_dst[bc+k], c_data[bc+k]}, {ed[k], ex[k]});
    end

    summary();
    $finish;
  end

endmodule